// File: doc/BRIEF.md
# Eight-line I/O port with per-line edge interrupts

The block gives eight general purpose lines, each of which software can make an input or an output through a byte-wide register interface. Output lines drive the level stored in a data register, and input lines keep their drivers off. A read of the data register returns stored bits for outputs and sampled pin levels for inputs. Input pins pass through a two-stage synchronizer before they reach the read path or the edge detectors.

Each line can raise an interrupt on a rising or a falling edge, chosen per bit, and only when its enable bit is set. A qualifying edge sets that line's pending bit. All pending bits merge into one interrupt request. The highest-numbered pending line wins, and the block presents an 8-bit vector built from a software-set 4-bit base and the winning line's index. An acknowledge clears the winning pending bit. Software can also clear pending bits by writing zeros.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is asserted and after its release, every register reads 0, `pin_oe` is 0, `irq` is 0 and `irq_vec` is 0.
- R2: `pin_oe[i]` equals direction bit i (offset 2, 1 = output). An input line keeps `pin_oe[i]` at 0 after any write to the data register.
- R3: `pin_out[i]` equals data register bit i (offset 0).
- R4: A read at offset 0 returns, per bit, the data register bit when the line is an output and the synchronized pin level when it is an input.
- R5: A pin change is visible on an offset-0 read after two rising clock edges, and not after one.
- R6: Edge bit i (offset 1) selects the edge that line i detects: 1 selects low-to-high and 0 selects high-to-low. A qualifying edge sets pending bit i on the third rising clock edge after the pin changes.
- R7: A pending bit is set only if its enable bit (offset 3) is 1. `irq` is 1 exactly when any pending bit (offset 4) is 1.
- R8: While `irq` is 1, `irq_vec` equals {base[3:0], idx[2:0], 1'b0}. Here idx is the highest-numbered pending line and base is bits 7:4 at offset 5. While `irq` is 0, `irq_vec` is 0.
- R9: A clock edge that samples `irq_ack` = 1 while `irq` = 1 clears the pending bit of the winning line, unless that line takes a new qualifying edge in the same cycle.
- R10: Writing offset 4 clears each pending bit written as 0 and leaves bits written as 1 unchanged. A qualifying edge in the same cycle sets its bit anyway.
- R11: Offsets 1, 2, 3 read back the last value written. Offset 5 reads the base in bits 7:4 with 0 in bits 3:0. Offsets 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from `bus_addr`) |
| pin_in | input | 8 | Pin levels seen at the pads |
| pin_out | output | 8 | Levels driven onto the pads |
| pin_oe | output | 8 | Per-line output enable |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq_vec | output | 8 | Vector of the winning line |

## Verification
A register write takes effect at the clock edge that samples `bus_wr`. So `pin_out`, `pin_oe` and the read-back value change right after that edge. A pin change needs two edges before it shows on the read path and a third before it sets a pending bit. An acknowledge or a pending write changes `irq` and `irq_vec` one edge later. The reference model in the bench keeps the same number of stages, updates at each rising edge and is compared at each falling edge. Directed checks sample one and two edges after a pin change to show that the synchronizer latency is exact.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    REG_DATA  = 3'd0,
    REG_EDGE  = 3'd1,
    REG_DIR   = 3'd2,
    REG_IEN   = 3'd3,
    REG_PEND  = 3'd4,
    REG_VBASE = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] stg_d;
    if (g == 0) begin : g_first
      assign stg_d = d;
    end else begin : g_rest
      assign stg_d = stg_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= '0;
      else        stg_q[g] <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] rise_sel,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur;
  end

  assign hit = (cur & ~prev_q & rise_sel) | (~cur & prev_q & ~rise_sel);
endmodule

// File: rtl/gpio_prio.sv
module gpio_prio #(
  parameter int W     = 8,
  parameter int IDX_W = 3
) (
  input  logic [W-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (req[i]) begin
        any = 1'b1;
        idx = i[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_port_pkg::*;
#(
  parameter int N_LINES     = 8,
  parameter int VEC_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [N_LINES-1:0] bus_wdata,
  output logic [N_LINES-1:0] bus_rdata,
  input  logic [N_LINES-1:0] pin_in,
  output logic [N_LINES-1:0] pin_out,
  output logic [N_LINES-1:0] pin_oe,
  output logic               irq,
  input  logic               irq_ack,
  output logic [VEC_W-1:0]   irq_vec
);
  localparam int IDX_W  = $clog2(N_LINES);
  localparam int BASE_W = VEC_W - IDX_W - 1;

  logic [N_LINES-1:0] dat_q, dat_d, edg_q, edg_d, dir_q, dir_d;
  logic [N_LINES-1:0] ien_q, ien_d, pend_q, pend_d;
  logic [BASE_W-1:0]  vbase_q, vbase_d;
  logic [N_LINES-1:0] pin_sync, edge_hit, edge_set, ack_clr, sw_clr;
  logic               win_any;
  logic [IDX_W-1:0]   win_idx;
  logic               wr_dat, wr_edg, wr_dir, wr_ien, wr_pend, wr_vbase;

  gpio_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  gpio_edge #(.W(N_LINES)) u_edge (
    .clk(clk), .rst_n(rst_n), .cur(pin_sync), .rise_sel(edg_q), .hit(edge_hit)
  );

  gpio_prio #(.W(N_LINES), .IDX_W(IDX_W)) u_prio (
    .req(pend_q), .any(win_any), .idx(win_idx)
  );

  assign wr_dat   = bus_wr && (bus_addr == REG_DATA);
  assign wr_edg   = bus_wr && (bus_addr == REG_EDGE);
  assign wr_dir   = bus_wr && (bus_addr == REG_DIR);
  assign wr_ien   = bus_wr && (bus_addr == REG_IEN);
  assign wr_pend  = bus_wr && (bus_addr == REG_PEND);
  assign wr_vbase = bus_wr && (bus_addr == REG_VBASE);

  assign edge_set = edge_hit & ien_q;
  assign ack_clr  = (irq_ack && win_any) ? (N_LINES'(1) << win_idx) : '0;
  assign sw_clr   = wr_pend ? ~bus_wdata : '0;

  always_comb begin
    dat_d   = wr_dat   ? bus_wdata : dat_q;
    edg_d   = wr_edg   ? bus_wdata : edg_q;
    dir_d   = wr_dir   ? bus_wdata : dir_q;
    ien_d   = wr_ien   ? bus_wdata : ien_q;
    vbase_d = wr_vbase ? bus_wdata[N_LINES-1 -: BASE_W] : vbase_q;
    pend_d  = (pend_q & ~(ack_clr | sw_clr)) | edge_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q   <= '0;
      edg_q   <= '0;
      dir_q   <= '0;
      ien_q   <= '0;
      pend_q  <= '0;
      vbase_q <= '0;
    end else begin
      dat_q   <= dat_d;
      edg_q   <= edg_d;
      dir_q   <= dir_d;
      ien_q   <= ien_d;
      pend_q  <= pend_d;
      vbase_q <= vbase_d;
    end
  end

  always_comb begin
    case (bus_addr)
      REG_DATA:  bus_rdata = (dir_q & dat_q) | (~dir_q & pin_sync);
      REG_EDGE:  bus_rdata = edg_q;
      REG_DIR:   bus_rdata = dir_q;
      REG_IEN:   bus_rdata = ien_q;
      REG_PEND:  bus_rdata = pend_q;
      REG_VBASE: bus_rdata = {vbase_q, {(N_LINES-BASE_W){1'b0}}};
      default:   bus_rdata = '0;
    endcase
  end

  assign pin_out = dat_q;
  assign pin_oe  = dir_q;
  assign irq     = win_any;
  assign irq_vec = win_any ? {vbase_q, win_idx, 1'b0} : '0;

  // R7
  pend_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(ien_q)) == '0));

  // R8
  vec_points_at_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend_q[irq_vec[IDX_W:1]]);

  // R8
  vec_is_highest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (((pend_q >> irq_vec[IDX_W:1]) >> 1) == '0));

  // R9
  ack_clears_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq && !edge_set[win_idx]) |=> !pend_q[$past(win_idx)]);

  // R10
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend |=> ((pend_q & ~$past(bus_wdata) & ~$past(edge_set)) == '0));
endmodule

// File: tb/gpio_irq_port_bench.sv
module gpio_irq_port_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, bus_wr, irq_ack;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata, pin_in, pin_out, pin_oe, irq_vec;
  logic       irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  gpio_irq_port u_gpio_irq_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .irq_ack(irq_ack),
    .irq_vec(irq_vec)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  int m_dat, m_edg, m_dir, m_ien, m_pend, m_vb, mq1, mq2, mq3;

  function automatic int top_bit(int v);
    for (int i = 7; i >= 0; i--) if (v[i]) return i;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dat = 0; m_edg = 0; m_dir = 0; m_ien = 0; m_pend = 0; m_vb = 0;
      mq1 = 0; mq2 = 0; mq3 = 0;
    end else begin
      int rise, fall, hit, clr;
      rise = mq2 & ~mq3 & 255;
      fall = ~mq2 & mq3 & 255;
      hit  = ((rise & m_edg) | (fall & ~m_edg)) & m_ien & 255;
      clr  = 0;
      if (irq_ack && m_pend != 0) clr = clr | (1 << top_bit(m_pend));
      if (bus_wr && bus_addr == 3'd4) clr = clr | (~int'(bus_wdata) & 255);
      if (bus_wr) begin
        case (bus_addr)
          3'd0: m_dat = bus_wdata;
          3'd1: m_edg = bus_wdata;
          3'd2: m_dir = bus_wdata;
          3'd3: m_ien = bus_wdata;
          3'd5: m_vb  = bus_wdata >> 4;
          default: ;
        endcase
      end
      m_pend = ((m_pend & ~clr) | hit) & 255;
      mq3 = mq2; mq2 = mq1; mq1 = pin_in;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_rd(int a);
    case (a)
      0: return ((m_dir & m_dat) | (~m_dir & mq2)) & 255;
      1: return m_edg;
      2: return m_dir;
      3: return m_ien;
      4: return m_pend;
      5: return (m_vb << 4) & 255;
      default: return 0;
    endcase
  endfunction

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 pin_oe", pin_oe, m_dir);
      chk("R3 pin_out", pin_out, m_dat);
      chk("R7 irq", irq, (m_pend != 0) ? 1 : 0);
      chk("R8 irq_vec", irq_vec, (m_pend != 0) ? ((m_vb << 4) | (top_bit(m_pend) << 1)) : 0);
      if (bus_addr == 3'd0) chk("R4 rdata data", bus_rdata, exp_rd(0));
      else                  chk("R11 rdata reg", bus_rdata, exp_rd(bus_addr));
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); #1;
    bus_wr = 1'b1; bus_addr = a[2:0]; bus_wdata = d[7:0];
    @(negedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk); #1;
    bus_addr = a[2:0];
    #1 v = bus_rdata;
  endtask

  task automatic setpin(int v);
    @(negedge clk); #1;
    pin_in = v[7:0];
  endtask

  task automatic ack();
    @(negedge clk); #1;
    irq_ack = 1'b1;
    @(negedge clk); #1;
    irq_ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int v;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    pin_in = '0; irq_ack = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 oe in reset", pin_oe, 0);
    chk("R1 irq in reset", irq, 0);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      chk("R1 reg after reset", v, 0);
    end
    chk("R1 vec after reset", irq_vec, 0);

    // register map readback
    wr(2, 'hF0); wr(0, 'hA5); wr(1, 'h0F); wr(5, 'hB7);
    rd(1, v); chk("R11 edge readback", v, 'h0F);
    rd(2, v); chk("R11 dir readback", v, 'hF0);
    rd(5, v); chk("R11 base readback", v, 'hB0);
    rd(6, v); chk("R11 offset 6", v, 0);
    rd(7, v); chk("R11 offset 7", v, 0);
    chk("R2 oe follows dir", pin_oe, 'hF0);
    chk("R3 out follows data", pin_out, 'hA5);

    // mixed read
    setpin('h3C);
    repeat (3) @(negedge clk);
    rd(0, v); chk("R4 mixed read", v, 'hAC);

    // synchronizer latency
    wr(2, 'h00);
    setpin('h00);
    repeat (3) @(negedge clk);
    setpin('hFF);
    rd(0, v); chk("R5 one edge old", v, 'h00);
    rd(0, v); chk("R5 two edges new", v, 'hFF);
    chk("R2 inputs stay off", pin_oe, 0);
    rd(4, v); chk("R7 no pend when disabled", v, 0);

    // edge polarity
    wr(3, 'h03); wr(1, 'h01); wr(4, 'h00);
    setpin('hFC);
    repeat (3) @(negedge clk);
    rd(4, v); chk("R6 falling on bit1 only", v, 'h02);
    setpin('hFF);
    repeat (3) @(negedge clk);
    rd(4, v); chk("R6 rising on bit0", v, 'h03);
    chk("R8 vec line1", irq_vec, 'hB2);

    // priority
    wr(1, 'hFF); wr(3, 'hFF);
    setpin('hBF);
    repeat (3) @(negedge clk);
    setpin('hFF);
    repeat (3) @(negedge clk);
    rd(4, v); chk("R6 bit6 rise", v, 'h43);
    chk("R8 vec line6", irq_vec, 'hBC);

    // acknowledge
    ack(); rd(4, v); chk("R9 ack clears 6", v, 'h03);
    ack(); rd(4, v); chk("R9 ack clears 1", v, 'h01);
    chk("R8 vec line0", irq_vec, 'hB0);
    ack(); rd(4, v); chk("R9 ack clears 0", v, 'h00);
    chk("R7 irq low", irq, 0);
    chk("R8 vec zero", irq_vec, 0);

    // software clear
    setpin('h00);
    repeat (3) @(negedge clk);
    setpin('hFF);
    repeat (3) @(negedge clk);
    rd(4, v); chk("R10 all pending", v, 'hFF);
    wr(4, 'hF0); rd(4, v); chk("R10 zero clears", v, 'hF0);
    wr(4, 'h0F); rd(4, v); chk("R10 one keeps", v, 'h00);

    // random traffic against the model
    for (int c = 0; c < 600; c++) begin
      @(negedge clk); #1;
      pin_in    = 8'($urandom);
      bus_wr    = ($urandom % 4) == 0;
      bus_addr  = 3'($urandom);
      bus_wdata = 8'($urandom);
      irq_ack   = ($urandom % 5) == 0;
    end
    @(negedge clk); #1;
    bus_wr = 1'b0; irq_ack = 1'b0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule